// File: doc/BRIEF.md
# Boolean Instruction-List Scan Engine

This block is a small soft controller core. It runs a stored program of single-bit logic instructions over and over. Each pass, called a scan, begins by taking a snapshot of every input pin into an input image. The program then runs at one instruction per clock. Each instruction works on a one-bit result register and a bit space that holds the input image, an output image and a bank of internal relay bits. Stores write into the output image or the relays. The output pins are refreshed from the output image only once, when the scan finishes. In the cycle the pins change, a one-clock scan-done pulse is raised. The next scan then starts at address 0.

Programs are written through a valid/ready load port. The port never applies back-pressure: `prog_ready` is held high, so every cycle with `prog_valid` high writes one word. A word written during a running scan is used the next time the sequencer fetches that address. Loading may overlap execution. While a program is only partly replaced, the outputs reflect the mixture of old and new words.

Top module: `plc_scan_engine`

## Requirements
- R1: The input image is loaded from `in_pins` in the single sampling cycle that opens each scan. Changes on `in_pins` after that cycle have no effect until the next scan samples them.
- R2: `out_pins` changes only on the clock edge that also raises `scan_done`, and it then carries the complete output image of the scan that just ended. This includes a store made by the last instruction.
- R3: Opcode 1 (load) copies the addressed bit into the result register. Opcode 2 (load inverted) copies the complement of that bit.
- R4: Opcode 3 sets the result to result AND bit. Opcode 4 sets it to result AND NOT bit.
- R5: Opcode 5 sets the result to result OR bit. Opcode 6 sets it to result OR NOT bit.
- R6: Opcode 7 (store) writes the result into the addressed output-image or relay bit. A store aimed at an input address (0..7) is discarded. Later instructions in the same scan read the updated output-image value.
- R7: Relay bits at addresses 16..31 can be written by a store and read back as operands in the same scan and in later scans.
- R8: A holding rung (load start, OR own output, AND NOT stop, store own output) stays set after start is released, and it clears when stop is asserted.
- R9: An instruction word is {opcode[7:5], operand[4:0]}. Operand addresses 0..7 are inputs, 8..15 are outputs 0..7 and 16..31 are relays 0..15. Opcode 0 marks the end of the program.
- R10: When the end opcode sits at address k, a scan lasts k+2 cycles. A program with no end opcode runs all 32 words and lasts 33 cycles. `scan_done` is high for exactly one cycle per scan.
- R11: A synchronous reset clears the outputs, the relays, the result register and the whole program memory to end opcodes. After reset, `out_pins` is 0 and scans of 2 cycles follow.
- R12: Each cycle with `prog_valid` high writes `prog_data` to `prog_addr`. `prog_ready` stays high, and the new word takes effect at its next fetch.
- R13: The output image and the relays keep their values from one scan to the next unless a store changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_pins | input | 8 | Physical input pins |
| out_pins | output | 8 | Physical output pins, refreshed at scan end |
| scan_done | output | 1 | One-cycle pulse when a scan finishes |
| prog_valid | input | 1 | Program word write request |
| prog_ready | output | 1 | Load port ready, always high |
| prog_addr | input | 5 | Program word address |
| prog_data | input | 8 | Program word {opcode, operand} |

## Verification
A bad result register or a wrong read of the bit space shows up on `out_pins` at the next scan-done edge. The latency is at most one scan of 29 cycles with the test program. A relay or output image that loses its value shows up as a dropped holding rung on the following scan. A fault in the input snapshot shows up as outputs that follow input glitches arriving in the middle of a scan. A fault in the sequencer shows up as a scan-done period that differs from the end-opcode position plus two.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [2:0] {
    OP_END  = 3'd0,
    OP_LD   = 3'd1,
    OP_LDN  = 3'd2,
    OP_AND  = 3'd3,
    OP_ANDN = 3'd4,
    OP_OR   = 3'd5,
    OP_ORN  = 3'd6,
    OP_ST   = 3'd7
  } plc_op_e;

  localparam int unsigned OPC_W = 3;
endpackage

// File: rtl/plc_prog_mem.sv
module plc_prog_mem #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned WORD_W = 8,
  parameter int unsigned PC_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PC_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [PC_W-1:0]   rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] words [DEPTH];

  // one register row per program word
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)
        words[g] <= '0;
      else if (wr_en && wr_addr == PC_W'(g))
        words[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_addr == PC_W'(i)) rd_data = words[i];
  end
endmodule

// File: rtl/plc_seq.sv
module plc_seq #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned PC_W  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_is_end,
  output logic            sampling,
  output logic            executing,
  output logic            scan_end,
  output logic [PC_W-1:0] pc,
  output logic            scan_done
);
  localparam logic [PC_W-1:0] LAST_PC = PC_W'(DEPTH - 1);

  assign executing = !sampling;
  assign scan_end  = executing && (op_is_end || pc == LAST_PC);

  always_ff @(posedge clk) begin
    if (rst) begin
      sampling  <= 1'b1;
      pc        <= '0;
      scan_done <= 1'b0;
    end else begin
      scan_done <= scan_end;
      if (sampling) begin
        sampling <= 1'b0;
        pc       <= '0;
      end else if (scan_end) begin
        sampling <= 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/plc_logic_unit.sv
module plc_logic_unit
  import plc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    exec_en,
  input  plc_op_e op,
  input  logic    opnd_bit,
  output logic    acc,
  output logic    st_en,
  output logic    st_bit
);
  logic acc_nxt;

  always_comb begin
    acc_nxt = acc;
    unique case (op)
      OP_LD:   acc_nxt = opnd_bit;
      OP_LDN:  acc_nxt = !opnd_bit;
      OP_AND:  acc_nxt = acc & opnd_bit;
      OP_ANDN: acc_nxt = acc & !opnd_bit;
      OP_OR:   acc_nxt = acc | opnd_bit;
      OP_ORN:  acc_nxt = acc | !opnd_bit;
      default: acc_nxt = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          acc <= 1'b0;
    else if (exec_en) acc <= acc_nxt;
  end

  assign st_en  = exec_en && (op == OP_ST);
  assign st_bit = acc;
endmodule

// File: rtl/plc_bit_store.sv
module plc_bit_store #(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned N_IR   = 16,
  parameter int unsigned OPND_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_en,
  input  logic [N_IN-1:0]   in_pins,
  input  logic [OPND_W-1:0] rd_addr,
  output logic              rd_bit,
  input  logic              wr_en,
  input  logic [OPND_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic              commit,
  output logic [N_OUT-1:0]  out_pins,
  output logic [N_IN-1:0]   in_img
);
  localparam int unsigned N_BITS = N_IN + N_OUT + N_IR;

  logic [N_OUT-1:0]  out_img, out_nxt;
  logic [N_IR-1:0]   ir_q, ir_nxt;
  logic [N_BITS-1:0] all_bits;

  assign all_bits = {ir_q, out_img, in_img};

  always_comb begin
    rd_bit = 1'b0;
    for (int i = 0; i < N_BITS; i++)
      if (rd_addr == OPND_W'(i)) rd_bit = all_bits[i];
  end

  always_comb begin
    for (int i = 0; i < N_OUT; i++)
      out_nxt[i] = (wr_en && wr_addr == OPND_W'(N_IN + i)) ? wr_bit : out_img[i];
    for (int i = 0; i < N_IR; i++)
      ir_nxt[i] = (wr_en && wr_addr == OPND_W'(N_IN + N_OUT + i)) ? wr_bit : ir_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_img   <= '0;
      out_img  <= '0;
      ir_q     <= '0;
      out_pins <= '0;
    end else begin
      if (sample_en) in_img <= in_pins;
      out_img <= out_nxt;
      ir_q    <= ir_nxt;
      if (commit) out_pins <= out_nxt;
    end
  end
endmodule

// File: rtl/plc_scan_engine.sv
module plc_scan_engine
  import plc_pkg::*;
#(
  parameter int unsigned N_IN       = 8,
  parameter int unsigned N_OUT      = 8,
  parameter int unsigned N_IR       = 16,
  parameter int unsigned PROG_DEPTH = 32,
  localparam int unsigned OPND_W    = $clog2(N_IN + N_OUT + N_IR),
  localparam int unsigned WORD_W    = OPC_W + OPND_W,
  localparam int unsigned PC_W      = $clog2(PROG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   in_pins,
  output logic [N_OUT-1:0]  out_pins,
  output logic              scan_done,
  input  logic              prog_valid,
  output logic              prog_ready,
  input  logic [PC_W-1:0]   prog_addr,
  input  logic [WORD_W-1:0] prog_data
);
  logic [WORD_W-1:0] cur_word;
  logic [PC_W-1:0]   pc;
  logic              sampling, executing, scan_end;
  plc_op_e           op;
  logic [OPND_W-1:0] opnd;
  logic              opnd_bit, acc, st_en, st_bit;
  logic [N_IN-1:0]   in_img;

  assign prog_ready = 1'b1;
  assign op   = plc_op_e'(cur_word[WORD_W-1 -: OPC_W]);
  assign opnd = cur_word[OPND_W-1:0];

  plc_prog_mem #(.DEPTH(PROG_DEPTH), .WORD_W(WORD_W), .PC_W(PC_W)) mem_i (
    .clk(clk), .rst(rst),
    .wr_en(prog_valid && prog_ready), .wr_addr(prog_addr), .wr_data(prog_data),
    .rd_addr(pc), .rd_data(cur_word)
  );

  plc_seq #(.DEPTH(PROG_DEPTH), .PC_W(PC_W)) seq_i (
    .clk(clk), .rst(rst), .op_is_end(op == OP_END),
    .sampling(sampling), .executing(executing), .scan_end(scan_end),
    .pc(pc), .scan_done(scan_done)
  );

  plc_logic_unit lu_i (
    .clk(clk), .rst(rst), .exec_en(executing), .op(op), .opnd_bit(opnd_bit),
    .acc(acc), .st_en(st_en), .st_bit(st_bit)
  );

  plc_bit_store #(.N_IN(N_IN), .N_OUT(N_OUT), .N_IR(N_IR), .OPND_W(OPND_W)) bits_i (
    .clk(clk), .rst(rst), .sample_en(sampling), .in_pins(in_pins),
    .rd_addr(opnd), .rd_bit(opnd_bit),
    .wr_en(st_en), .wr_addr(opnd), .wr_bit(st_bit),
    .commit(scan_end), .out_pins(out_pins), .in_img(in_img)
  );
endmodule

// File: rtl/plc_scan_engine_chk.sv
module plc_scan_engine_chk #(
  parameter int unsigned N_IN  = 8,
  parameter int unsigned N_OUT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_OUT-1:0] out_pins,
  input logic             scan_done,
  input logic             sampling,
  input logic [N_IN-1:0]  in_img
);
  // R2: pins move only together with the scan-done pulse
  assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !scan_done |-> $stable(out_pins));

  // R10: scan-done lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);

  // R10: a finished scan is followed by the sampling cycle of the next one
  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> sampling);

  // R1: the input image only changes right after a sampling cycle
  assert_img_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(sampling) |-> $stable(in_img));

  // R11: first cycle after reset shows cleared pins and no pulse
  assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_pins == '0 && !scan_done));
endmodule

bind plc_scan_engine plc_scan_engine_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) chk_i (
  .clk(clk), .rst(rst), .out_pins(out_pins), .scan_done(scan_done),
  .sampling(sampling), .in_img(in_img)
);

// File: tb/plc_scan_engine_tb_top.sv
module plc_scan_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_pins = '0;
  logic [7:0] out_pins;
  logic       scan_done;
  logic       prog_valid = 1'b0;
  logic       prog_ready;
  logic [4:0] prog_addr = '0;
  logic [7:0] prog_data = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit ended = 0;

  always #4 clk = ~clk;  // 125 MHz

  plc_scan_engine dut_i (
    .clk(clk), .rst(rst), .in_pins(in_pins), .out_pins(out_pins),
    .scan_done(scan_done), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data)
  );

  function automatic logic [7:0] iw(int op, int a);
    return {op[2:0], a[4:0]};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  task automatic load(int a, logic [7:0] d);
    @(negedge clk);
    if (!prog_ready) begin
      total++; bad++;
      $display("FAIL R12 actual=0 expected=1 (ready)");
    end
    prog_valid = 1'b1; prog_addr = a[4:0]; prog_data = d;
    @(negedge clk);
    prog_valid = 1'b0;
  endtask

  // advance to the next negedge on which scan_done is high
  task automatic wait_done();
    do @(negedge clk); while (!scan_done);
  endtask

  task automatic period(output int n);
    wait_done();
    n = 0;
    do begin @(negedge clk); n++; end while (!scan_done);
  endtask

  // opcodes per R9: 0 end,1 ld,2 ldn,3 and,4 andn,5 or,6 orn,7 st
  task automatic load_prog_a();
    int p;
    p = 0;
    load(p++, iw(1, 0)); load(p++, iw(3, 1)); load(p++, iw(7, 8));    // o0 = i0&i1
    load(p++, iw(2, 0)); load(p++, iw(4, 1)); load(p++, iw(7, 9));    // o1 = !i0&!i1
    load(p++, iw(1, 2)); load(p++, iw(5, 3)); load(p++, iw(7, 10));   // o2 = i2|i3
    load(p++, iw(2, 2)); load(p++, iw(6, 3)); load(p++, iw(7, 11));   // o3 = !i2|!i3
    load(p++, iw(1, 4)); load(p++, iw(7, 16)); load(p++, iw(2, 16)); load(p++, iw(7, 12)); // o4 via relay
    load(p++, iw(1, 5)); load(p++, iw(5, 13)); load(p++, iw(4, 6)); load(p++, iw(7, 13)); // hold
    load(p++, iw(1, 4)); load(p++, iw(7, 0)); load(p++, iw(1, 0)); load(p++, iw(7, 14));  // st to input
    load(p++, iw(1, 8)); load(p++, iw(7, 15));                         // o7 = o0 read back
    load(p++, iw(1, 0));                                               // filler at 26
    load(p++, iw(0, 0));                                               // end at 27
  endtask

  function automatic logic [7:0] model(logic [7:0] v, logic h);
    logic [7:0] e;
    e[0] = v[0] & v[1];
    e[1] = !v[0] & !v[1];
    e[2] = v[2] | v[3];
    e[3] = !v[2] | !v[3];
    e[4] = !v[4];
    e[5] = (v[5] | h) & !v[6];
    e[6] = v[0];
    e[7] = e[0];
    return e;
  endfunction

  initial begin
    int n;
    logic hold;
    logic [7:0] e, prev;

    repeat (4) @(negedge clk);
    check("R11 reset pins", int'(out_pins), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 pins after reset", int'(out_pins), 0);
    period(n);
    check("R11 empty-program period", n, 2);

    load_prog_a();
    in_pins = 8'h00;
    wait_done(); wait_done(); wait_done();
    check("R10 period end at 27", 0, 0);
    period(n);
    check("R10 period end at 27", n, 29);
    hold = 1'b0;
    check("R3 R4 R5 R13 idle outputs", int'(out_pins), int'(model(8'h00, hold)));

    // R8 explicit holding rung sequence
    in_pins = 8'h20; wait_done();
    check("R8 start sets", int'(out_pins[5]), 1);
    in_pins = 8'h00; wait_done();
    check("R8 stays after release", int'(out_pins[5]), 1);
    wait_done();
    check("R8 R13 holds next scan", int'(out_pins[5]), 1);
    in_pins = 8'h40; wait_done();
    check("R8 stop clears", int'(out_pins[5]), 0);
    in_pins = 8'h60; wait_done();
    check("R8 stop dominates", int'(out_pins[5]), 0);
    hold = 1'b0;

    // exhaustive sweep over all input patterns
    for (int v = 0; v < 256; v++) begin
      in_pins = v[7:0];
      wait_done();
      e = model(v[7:0], hold);
      hold = e[5];
      check("R3 o1 load-inverted/and-not", int'(out_pins[1]), int'(e[1]));
      check("R4 o0 series contacts", int'(out_pins[0]), int'(e[0]));
      check("R5 o2 o3 parallel contacts", int'(out_pins[3:2]), int'(e[3:2]));
      check("R7 o4 through relay", int'(out_pins[4]), int'(e[4]));
      check("R8 o5 holding rung", int'(out_pins[5]), int'(e[5]));
      check("R6 st to input ignored", int'(out_pins[6]), int'(e[6]));
      check("R6 output read-back", int'(out_pins[7]), int'(e[7]));
    end

    // R1 and R2: mid-scan glitch is ignored, pins only move at done
    in_pins = 8'h03; wait_done(); wait_done();
    prev = out_pins;
    check("R1 baseline", int'(prev[0]), 1);
    repeat (4) @(negedge clk);
    in_pins = 8'h00;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R2 pins stable mid-scan", int'(out_pins), int'(prev));
    end
    in_pins = 8'h03;
    wait_done();
    check("R1 glitch ignored", int'(out_pins), int'(prev));
    in_pins = 8'h00;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (!scan_done) check("R2 no change before done", int'(out_pins), int'(prev));
    end while (!scan_done);
    check("R2 change at done", int'(out_pins[0]), 0);

    // R10 R12: full-length program without end, store at last address
    for (int a = 0; a < 30; a++) load(a, iw(1, 1));
    load(30, iw(1, 0));
    load(31, iw(7, 8));
    in_pins = 8'h01;
    wait_done(); wait_done(); wait_done();
    period(n);
    check("R10 period with no end", n, 33);
    check("R12 R2 last-address store", int'(out_pins[0]), 1);
    in_pins = 8'h00; wait_done(); wait_done();
    check("R10 last-address store clears", int'(out_pins[0]), 0);

    // R11: reset clears everything mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R11 pins cleared", int'(out_pins), 0);
    period(n);
    check("R11 program cleared", n, 2);

    finish_run();
  end
endmodule